// File: doc/BRIEF.md
# Timer Capture/Compare PWM Channel

This block is one channel of a free-running up-counter timer. The same channel register serves two jobs. In capture mode it stores the count at a chosen edge of an external input. In compare mode it holds the match value that shapes a pulse-width-modulated output. Software reaches every register through a byte-wide bus, so a count-wide channel value takes two accesses. Interlocks keep those two halves coherent. Reading the high byte freezes captures until the low byte has been read. Writing the high byte suspends compare matches until the low byte arrives.

The counter runs from zero up to a programmable period, then wraps. Each wrap sets an overflow flag and starts a new output period. The output goes active at the wrap and inactive at the compare match. A toggle option makes the output change state on each wrap instead. A max-duty control holds the output fully active. A change to that control takes effect only at a period boundary, so a period that has already started is never cut short.

Top module: `tmr_ccp_channel`

## Requirements
- R1: The counter counts up by one each clock from 0 and returns to 0 on the clock after it reaches or passes the period register. The period register resets to all ones. Each wrap sets the overflow flag, which is status bit 1.
- R2: Control bits [1:0] select the mode: 00 is input capture, and any other code is compare/PWM. Captures happen only in mode 00. The output is held at 0 in mode 00.
- R3: The capture input passes through a two-flop synchroniser. Control bits [3:2] choose the edge: 01 rising, 10 falling, 11 both, 00 none. An input change made between edges E-1 and E0 stores the count held between E1 and E2. A change that does not match the chosen edge leaves the channel register unchanged.
- R4: In capture mode, reading the channel high byte (address 4) blocks captures until the channel low byte (address 5) is read. Both bytes then return the value from before the lock.
- R5: In compare mode, writing the channel high byte suppresses compare matches and the channel flag until the low byte is written.
- R6: The channel flag is status bit 0. A capture or a compare match sets it. Writing 0 to a status bit clears that flag, and writing 1 has no effect.
- R7: In compare mode with toggle off, a wrap drives the output to 1 and a compare match drives it to 0. With a compare value below the period, the output is high for compare+1 cycles of every period+1.
- R8: With toggle on (control bit 4), the output inverts at each wrap, and compare matches do not change it.
- R9: Setting max-duty (control bit 5) while toggle is off leaves the current period unchanged. From the next wrap on, the output stays at 1 for whole periods.
- R10: After max-duty is cleared, the output stays at 1 until the next wrap, then resumes compare-driven PWM.
- R11: Register map, with read data valid one cycle after the read strobe: 0 control, 1 status, 2/3 period high/low, 4/5 channel high/low, 6/7 counter high/low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| cap_pin | input | 1 | Asynchronous capture input |
| pwm_out | output | 1 | Compare/PWM output, registered |

## Verification
The bench goes after the byte interlocks. It lands a capture edge between the high-byte and low-byte reads, and it waits several periods between the two halves of a compare write. A design without the read lock returns a torn value that mixes two captures. A design without the write lock raises the channel flag while only half the value has been written. The bench also toggles max-duty in the middle of a period. A design that applies the change at once cuts a pulse short or stretches it, while a design that never releases it stays stuck at full duty. Captured values are compared at the exact count that the two-stage synchroniser implies, so a missing or extra stage shifts every capture by one count.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int unsigned AW = 3;
  typedef logic [AW-1:0] ccp_addr_t;
  localparam ccp_addr_t A_CTRL = 3'd0;
  localparam ccp_addr_t A_STAT = 3'd1;
  localparam ccp_addr_t A_PERH = 3'd2;
  localparam ccp_addr_t A_PERL = 3'd3;
  localparam ccp_addr_t A_CHH  = 3'd4;
  localparam ccp_addr_t A_CHL  = 3'd5;
  localparam ccp_addr_t A_CNTH = 3'd6;
  localparam ccp_addr_t A_CNTL = 3'd7;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_t;
endpackage

// File: rtl/ccp_counter.sv
module ccp_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  assign wrap = (cnt >= period);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  p_wrap_zero_r1: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0));
  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    (!wrap && !$past(rst)) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/ccp_capture.sv
module ccp_capture #(
  parameter int unsigned SYNC = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pin,
  input  ccp_pkg::edge_sel_t  edge_sel,
  output logic                evt
);
  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic            rise, fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], pin};
      prev_q <= sync_q[SYNC-1];
    end
  end

  assign rise = sync_q[SYNC-1] & ~prev_q;
  assign fall = ~sync_q[SYNC-1] & prev_q;
  assign evt  = (rise & edge_sel[0]) | (fall & edge_sel[1]);

  p_no_edge_r3: assert property (@(posedge clk) disable iff (rst)
    (edge_sel == ccp_pkg::EDGE_NONE) |-> !evt);
endmodule

// File: rtl/ccp_pwm.sv
module ccp_pwm (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tov,
  input  logic maxd,
  input  logic wrap,
  input  logic match,
  output logic out,
  output logic maxd_eff
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out      <= 1'b0;
      maxd_eff <= 1'b0;
    end else begin
      if (wrap) maxd_eff <= maxd & ~tov;
      if (!en)                          out <= 1'b0;
      else if (wrap)                    out <= tov ? ~out : 1'b1;
      else if (match && !tov && !maxd_eff) out <= 1'b0;
    end
  end

  p_maxd_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (maxd_eff && !tov && en) |=> out);
  p_tov_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (en && tov && !wrap) |=> $stable(out));
  p_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> !out);
endmodule

// File: rtl/tmr_ccp_channel.sv
module tmr_ccp_channel #(
  parameter int unsigned CW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [CW/2-1:0]   bus_wdata,
  output logic [CW/2-1:0]   bus_rdata,
  input  logic              cap_pin,
  output logic              pwm_out
);
  import ccp_pkg::*;
  localparam int unsigned BW = CW / 2;

  logic [BW-1:0] ctrl;
  logic [CW-1:0] period, ch_reg, cnt;
  logic          chf, ovf, rd_lock, wr_lock;
  logic          wrap, edge_evt, cap_evt, match_evt, maxd_eff;
  logic [1:0]    mode;
  logic          cap_mode;
  logic          wr_chh, wr_chl, rd_chh, rd_chl, wr_stat;

  assign mode     = ctrl[1:0];
  assign cap_mode = (mode == 2'b00);
  assign wr_chh   = bus_wr && (bus_addr == A_CHH);
  assign wr_chl   = bus_wr && (bus_addr == A_CHL);
  assign rd_chh   = bus_rd && (bus_addr == A_CHH);
  assign rd_chl   = bus_rd && (bus_addr == A_CHL);
  assign wr_stat  = bus_wr && (bus_addr == A_STAT);

  ccp_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .period(period), .cnt(cnt), .wrap(wrap));

  ccp_capture #(.SYNC(SYNC_STAGES)) u_cap (
    .clk(clk), .rst(rst), .pin(cap_pin),
    .edge_sel(edge_sel_t'(ctrl[3:2])), .evt(edge_evt));

  assign cap_evt   = cap_mode && edge_evt && !rd_lock;
  assign match_evt = !cap_mode && !wr_lock && (cnt == ch_reg);

  ccp_pwm u_pwm (
    .clk(clk), .rst(rst), .en(!cap_mode), .tov(ctrl[4]), .maxd(ctrl[5]),
    .wrap(wrap), .match(match_evt), .out(pwm_out), .maxd_eff(maxd_eff));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      period <= '1;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTRL: ctrl <= bus_wdata;
        A_PERH: period[CW-1:BW] <= bus_wdata;
        A_PERL: period[BW-1:0]  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_chh)       ch_reg[CW-1:BW] <= bus_wdata;
    else if (wr_chl)  ch_reg[BW-1:0]  <= bus_wdata;
    else if (cap_evt) ch_reg          <= cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_lock <= 1'b0;
      wr_lock <= 1'b0;
      chf     <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      if (rd_chh && cap_mode) rd_lock <= 1'b1;
      else if (rd_chl)        rd_lock <= 1'b0;
      if (wr_chh && !cap_mode) wr_lock <= 1'b1;
      else if (wr_chl)         wr_lock <= 1'b0;
      if (cap_evt || match_evt)      chf <= 1'b1;
      else if (wr_stat && !bus_wdata[0]) chf <= 1'b0;
      if (wrap)                          ovf <= 1'b1;
      else if (wr_stat && !bus_wdata[1]) ovf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        A_CTRL:  bus_rdata <= ctrl;
        A_STAT:  bus_rdata <= {{(BW-2){1'b0}}, ovf, chf};
        A_PERH:  bus_rdata <= period[CW-1:BW];
        A_PERL:  bus_rdata <= period[BW-1:0];
        A_CHH:   bus_rdata <= ch_reg[CW-1:BW];
        A_CHL:   bus_rdata <= ch_reg[BW-1:0];
        A_CNTH:  bus_rdata <= cnt[CW-1:BW];
        default: bus_rdata <= cnt[BW-1:0];
      endcase
    end
  end

  p_rdlock_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_lock && !wr_chh && !wr_chl) |=> $stable(ch_reg));
  p_wrlock_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_lock && !cap_mode && !chf) |=> !chf);
  p_flag_src_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(chf) |-> $past(cap_evt || match_evt));
  p_ovf_src_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $past(wrap));
endmodule

// File: tb/sim_tmr_ccp_channel.sv
`timescale 1ns/1ps
module sim_tmr_ccp_channel;
  logic       clk = 1'b0, rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, cap_pin = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       pwm_out;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  tmr_ccp_channel u0 (.clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_pin(cap_pin), .pwm_out(pwm_out));

  // reference model built from the requirements
  logic [15:0] mcnt, mper, mch;
  logic [7:0]  mctrl;
  logic        mwl, m_out, m_eff;
  always @(posedge clk) begin
    logic w;
    if (rst) begin
      mcnt <= 0; mper <= 16'hFFFF; mctrl <= 0; mch <= 0;
      mwl <= 0; m_out <= 0; m_eff <= 0;
    end else begin
      w = (mcnt >= mper);
      mcnt <= w ? 16'h0 : mcnt + 1;
      if (bus_wr) case (bus_addr)
        3'd0: mctrl <= bus_wdata;
        3'd2: mper[15:8] <= bus_wdata;
        3'd3: mper[7:0] <= bus_wdata;
        3'd4: begin mch[15:8] <= bus_wdata; if (mctrl[1:0] != 0) mwl <= 1; end
        3'd5: begin mch[7:0] <= bus_wdata; mwl <= 0; end
        default: ;
      endcase
      if (w) m_eff <= mctrl[5] & ~mctrl[4];
      if (mctrl[1:0] == 0) m_out <= 0;
      else if (w) m_out <= mctrl[4] ? ~m_out : 1'b1;
      else if (!mctrl[4] && !m_eff && !mwl && mcnt == mch) m_out <= 0;
    end
  end

  function automatic logic [15:0] nxt(logic [15:0] c);
    return (c >= mper) ? 16'h0 : c + 16'h1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_w(logic [2:0] a, logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bus_r(logic [2:0] a, output logic [7:0] d, output logic [15:0] c);
    @(negedge clk); bus_rd = 1; bus_addr = a; c = mcnt;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic rd_ch(output logic [15:0] v);
    logic [7:0] h, l; logic [15:0] c;
    bus_r(3'd4, h, c); bus_r(3'd5, l, c);
    v = {h, l};
  endtask

  task automatic cap_set(logic v, output logic [15:0] e);
    @(negedge clk); e = nxt(nxt(mcnt)); cap_pin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_cnt(logic [15:0] k);
    @(negedge clk);
    while (mcnt != k) @(negedge clk);
  endtask

  task automatic span(int n, string req);
    repeat (n) begin
      @(negedge clk);
      chk(pwm_out == m_out, req, pwm_out, m_out);
    end
  endtask

  task automatic setup_pwm(logic [7:0] per, logic [7:0] cmp, logic [7:0] ctl);
    bus_w(3'd0, 8'h00);
    bus_w(3'd2, 8'h00); bus_w(3'd3, per);
    bus_w(3'd4, 8'h00); bus_w(3'd5, cmp);
    bus_w(3'd0, ctl);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d; logic [15:0] c, v, e1, e2, e3, mexp;
    int hi, tr; logic last;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;

    // reset state, R11 map
    bus_r(3'd0, d, c); chk(d == 8'h00, "R11 ctrl reset", d, 0);
    bus_r(3'd1, d, c); chk(d == 8'h00, "R6 stat reset", d, 0);
    bus_r(3'd2, d, c); chk(d == 8'hFF, "R1 period reset hi", d, 8'hFF);
    bus_r(3'd3, d, c); chk(d == 8'hFF, "R1 period reset lo", d, 8'hFF);
    chk(pwm_out == 0, "R2 out reset", pwm_out, 0);
    bus_r(3'd7, d, c); chk(d == c[7:0], "R1 counter read", d, c[7:0]);

    // captures, R3 / R4
    bus_w(3'd0, 8'h04);
    cap_set(1, e1); rd_ch(v); chk(v == e1, "R3 rising capture", v, e1);
    cap_set(0, e2); rd_ch(v); chk(v == e1, "R3 unselected edge", v, e1);
    bus_r(3'd1, d, c); chk(d[0] == 1, "R6 flag on capture", d[0], 1);
    bus_r(3'd4, d, c); chk(d == e1[15:8], "R4 hi read", d, e1[15:8]);
    cap_set(1, e2);
    bus_r(3'd5, d, c); chk(d == e1[7:0], "R4 lo held", d, e1[7:0]);
    rd_ch(v); chk(v == e1, "R4 capture blocked", v, e1);
    bus_w(3'd0, 8'h0C);
    cap_set(0, e3); rd_ch(v); chk(v == e3, "R4 capture after unlock", v, e3);
    mexp = e3;

    // random captures, R3
    for (int i = 0; i < 16; i++) begin
      logic [1:0] es; logic nv;
      es = 2'($urandom_range(1, 3)); nv = ~cap_pin;
      bus_w(3'd0, {4'h0, es, 2'b00});
      cap_set(nv, e1);
      if ((nv && es[0]) || (!nv && es[1])) mexp = e1;
      rd_ch(v); chk(v == mexp, "R3 random capture", v, mexp);
    end

    // mode nonzero ignores pin, R2
    bus_w(3'd0, 8'h0D);
    cap_set(~cap_pin, e1); cap_set(~cap_pin, e1);
    rd_ch(v); chk(v == mexp, "R2 no capture in compare mode", v, mexp);

    // PWM, R7
    setup_pwm(8'd19, 8'd5, 8'h01);
    wait_cnt(0); hi = 0;
    repeat (20) begin @(negedge clk); hi += pwm_out; end
    chk(hi == 6, "R7 high count", hi, 6);
    span(40, "R7 model");

    // flag clearing, R6 / R1
    bus_r(3'd1, d, c); chk(d == 8'h03, "R6 flags set", d, 3);
    wait_cnt(8); bus_w(3'd1, 8'hFF);
    bus_r(3'd1, d, c); chk(d == 8'h03, "R6 write one no effect", d, 3);
    wait_cnt(8); bus_w(3'd1, 8'h02);
    bus_r(3'd1, d, c); chk(d == 8'h02, "R6 clear chf", d, 2);
    wait_cnt(3); bus_w(3'd1, 8'h01);
    bus_r(3'd1, d, c); chk(d[1] == 0, "R1 ovf cleared", d[1], 0);
    wait_cnt(0); @(negedge clk);
    bus_r(3'd1, d, c); chk(d[1] == 1, "R1 ovf on wrap", d[1], 1);

    // write lock, R5
    wait_cnt(8); bus_w(3'd1, 8'h02); bus_w(3'd4, 8'h00);
    span(45, "R5 out during lock");
    bus_r(3'd1, d, c); chk(d[0] == 0, "R5 flag suppressed", d[0], 0);
    bus_w(3'd5, 8'd5);
    repeat (25) @(negedge clk);
    bus_r(3'd1, d, c); chk(d[0] == 1, "R5 flag after unlock", d[0], 1);

    // max-duty, R9 / R10
    wait_cnt(10); bus_w(3'd0, 8'h21);
    while (mcnt != 0) begin chk(pwm_out == 0, "R9 current period kept", pwm_out, 0); @(negedge clk); end
    for (int i = 0; i < 20; i++) begin chk(pwm_out == 1, "R9 full duty", pwm_out, 1); @(negedge clk); end
    wait_cnt(10); bus_w(3'd0, 8'h01);
    while (mcnt != 0) begin chk(pwm_out == 1, "R10 hold to boundary", pwm_out, 1); @(negedge clk); end
    for (int i = 0; i < 20; i++) begin
      chk(pwm_out == (mcnt <= 5), "R10 resume PWM", pwm_out, (mcnt <= 5));
      @(negedge clk);
    end

    // toggle on overflow, R8
    bus_w(3'd0, 8'h11);
    wait_cnt(3); last = pwm_out; tr = 0;
    repeat (40) begin @(negedge clk); if (pwm_out != last) tr++; last = pwm_out; end
    chk(tr == 2, "R8 toggles per two periods", tr, 2);
    span(40, "R8 model");

    // random PWM configurations, R7..R10, R1
    for (int i = 0; i < 8; i++) begin
      logic [7:0] per, cmp, ctl;
      per = 8'($urandom_range(8, 40)); cmp = 8'($urandom_range(0, per + 3));
      ctl = {2'b00, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 4'b0001};
      setup_pwm(per, cmp, ctl);
      span(3 * (per + 1), "R7 random PWM");
      bus_r(3'd7, d, c); chk(d == c[7:0], "R1 counter random", d, c[7:0]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule